// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit CPU core. Each of `NSRC` sources owns a pending flag, an enable bit and a priority bit. A single global enable sits above all the individual enables. Peripherals pulse a per-source event line, and software may set or clear any flag directly. Every clock cycle the controller picks the strongest eligible source and registers that choice. At the next instruction boundary reported by the CPU it raises a vector request. The request carries the handler address `VEC_BASE + (index << VEC_SHIFT)`, which is 0x0003 + 8 × index by default. The address stays on the bus until the CPU acknowledges it.

Two in-service bits record which levels have a handler running. While only a low-level handler is active, a high-level source may still be taken. While a high-level handler is active, nothing is taken. A return strobe from the CPU ends the innermost level. A boundary that is itself a return never starts a vector, so at least one further instruction runs before the next handler. Sources whose bit is set in the `AUTOCLR` parameter lose their pending flag when their vector is acknowledged. All other flags stay set until software clears them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A pulse on `hw_evt[i]` sets `pend[i]` on the following clock edge, whatever the values of `glob_en` and `src_en[i]`.
- R2: A source may cause a vector request only while `glob_en` is 1 and its `src_en` bit is 1. With `glob_en` at 0, no source ever raises `vec_req`.
- R3: A pulse on `sw_set[i]` sets `pend[i]` and leads to a vector just as a hardware event would. A pulse on `sw_clr[i]` clears the flag. When a set and a clear hit the same flag in the same cycle, the set wins.
- R4: Nesting rules:
  - With nothing in service, either level may be taken.
  - With only the low level in service, only a source whose priority bit is 1 may be taken.
  - With the high level in service, no source is taken.
- R5: Among the eligible sources, a priority bit of 1 (high) beats 0 (low). Within one level, the lowest index wins.
- R6: The controller detects a request in one cycle and may raise `vec_req` only at a clock edge where `insn_done` is 1. With `insn_done` held at 1, an event sampled at edge n gives `vec_req` = 1 after edge n+2 and not earlier.
- R7: `vec_addr` equals `0x0003 + 8 × index` for the chosen source. Both `vec_req` and `vec_addr` hold steady until `vec_ack` is seen, and `vec_req` drops at the edge that samples `vec_ack`.
- R8: An edge where `reti_done` is 1 never raises `vec_req`, even when a request is already detected. The first later edge with `insn_done` = 1 and `reti_done` = 0 may raise it.
- R9: On acknowledge, the chosen source's pending flag is cleared if its bit in `AUTOCLR` is 1 (sources 0 and 1 by default). Any other flag stays at 1.
- R10: Acknowledge sets `insv_hi` or `insv_lo`, matching the level of the acknowledged source. `reti_done` clears `insv_hi` if it is set, and otherwise clears `insv_lo`.
- R11: After reset, `vec_req`, `pend`, `insv_lo` and `insv_hi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt | input | NSRC | One-cycle trigger pulses from peripherals |
| sw_set | input | NSRC | Software write-one to set pending flags |
| sw_clr | input | NSRC | Software write-one to clear pending flags |
| glob_en | input | 1 | Global enable |
| src_en | input | NSRC | Per-source enables |
| src_prio | input | NSRC | Per-source level (1 = high) |
| insn_done | input | 1 | Instruction boundary strobe |
| reti_done | input | 1 | The boundary is a return from interrupt (asserted with insn_done) |
| vec_ack | input | 1 | CPU has taken the vector |
| vec_req | output | 1 | Vector request |
| vec_addr | output | 16 | Handler address |
| pend | output | NSRC | Pending flags |
| insv_lo | output | 1 | Low-level handler in service |
| insv_hi | output | 1 | High-level handler in service |

## Verification
The assertions assume a well-behaved CPU:
- `vec_ack` arrives only while `vec_req` is high.
- `reti_done` is raised only together with `insn_done`, and only while at least one level is in service.
- A return never falls in the same cycle as an acknowledge.

The stimulus keeps to these rules. The acknowledge comes only from the monitor, one cycle after it sees a request. Returns are issued by a single task that drives both strobes for one cycle. That task runs only after an acknowledge, and only once the acknowledge pulse has ended.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int ADDR_W = 16;
    localparam int IDX_W  = 8;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } irq_lvl_e;

    typedef struct packed {
        logic             valid;
        irq_lvl_e         lvl;
        logic [IDX_W-1:0] idx;
    } irq_pick_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } irq_insv_t;

    function automatic logic [ADDR_W-1:0] irq_vec_addr(
        input logic [ADDR_W-1:0] base,
        input int unsigned       shift,
        input logic [IDX_W-1:0]  idx
    );
        return base + (ADDR_W'(idx) << shift);
    endfunction

endpackage

// File: rtl/prio_irq_pend_bank.sv
module prio_irq_pend_bank #(
    parameter int              NSRC    = 8,
    parameter logic [NSRC-1:0] AUTOCLR = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] hw_evt,
    input  logic [NSRC-1:0] sw_set,
    input  logic [NSRC-1:0] sw_clr,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] pend
);

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        logic set_i;
        logic clr_i;

        assign set_i = hw_evt[i] | sw_set[i];

        if (AUTOCLR[i]) begin : g_auto
            assign clr_i = sw_clr[i] | ack_clr[i];

            // R9: an acknowledged auto-clear source drops its flag
            p_autoclr_r9: assert property (@(posedge clk) disable iff (rst)
                (ack_clr[i] && !set_i) |=> !pend[i]);
        end else begin : g_keep
            assign clr_i = sw_clr[i];
        end

        always_ff @(posedge clk) begin
            if (rst) pend[i] <= 1'b0;
            else     pend[i] <= set_i | (pend[i] & ~clr_i);
        end

        // R1: an event always lands in the flag
        p_evt_sets_r1: assert property (@(posedge clk) disable iff (rst)
            hw_evt[i] |=> pend[i]);
    end

endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_prio,
    input  logic            glob_en,
    input  irq_insv_t       insv,
    input  logic            hold,
    output irq_pick_t       pick
);

    logic [NSRC-1:0]  elig;
    logic [NSRC-1:0]  hi_cand;
    logic [NSRC-1:0]  lo_cand;
    logic             allow_hi;
    logic             allow_lo;
    logic             hi_hit;
    logic             lo_hit;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;
    irq_pick_t        pick_d;

    assign elig     = pend & src_en & {NSRC{glob_en}};
    assign hi_cand  = elig & src_prio;
    assign lo_cand  = elig & ~src_prio;
    assign allow_hi = ~insv.hi;
    assign allow_lo = ~insv.hi & ~insv.lo;

    always_comb begin
        hi_hit = 1'b0;
        lo_hit = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hi_cand[i]) begin
                hi_hit = 1'b1;
                hi_idx = IDX_W'(i);
            end
            if (lo_cand[i]) begin
                lo_hit = 1'b1;
                lo_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        pick_d = '0;
        if (hi_hit && allow_hi) begin
            pick_d.valid = 1'b1;
            pick_d.lvl   = LVL_HI;
            pick_d.idx   = hi_idx;
        end else if (lo_hit && allow_lo) begin
            pick_d.valid = 1'b1;
            pick_d.lvl   = LVL_LO;
            pick_d.idx   = lo_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) pick <= '0;
        else             pick <= pick_d;
    end

    // R4: nothing is picked while a high-level handler runs
    p_no_pick_in_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (insv.hi && !hold) |=> !pick.valid);

    // R2: a pick needs the global enable one cycle earlier
    p_glob_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (!glob_en) |=> !pick.valid);

endmodule

// File: rtl/prio_irq_nest.sv
module prio_irq_nest
    import prio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  irq_lvl_e  take_lvl,
    input  logic      ret,
    output irq_insv_t insv
);

    always_ff @(posedge clk) begin
        if (rst) begin
            insv <= '0;
        end else begin
            if (ret) begin
                if (insv.hi) insv.hi <= 1'b0;
                else         insv.lo <= 1'b0;
            end
            if (take) begin
                if (take_lvl == LVL_HI) insv.hi <= 1'b1;
                else                    insv.lo <= 1'b1;
            end
        end
    end

    // R10: a return ends the high level first
    p_ret_hi_first_r10: assert property (@(posedge clk) disable iff (rst)
        (ret && !take && insv.hi) |=> (!insv.hi && insv.lo == $past(insv.lo)));

    // R10: acknowledge marks the taken level
    p_take_marks_r10: assert property (@(posedge clk) disable iff (rst)
        take |=> (insv.hi || insv.lo));

endmodule

// File: rtl/prio_irq_vec_issue.sv
module prio_irq_vec_issue
    import prio_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0003,
    parameter int unsigned       VEC_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  irq_pick_t         pick,
    input  logic              insn_done,
    input  logic              reti_done,
    input  logic              vec_ack,
    input  irq_insv_t         insv,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [IDX_W-1:0]  vec_idx,
    output irq_lvl_e          vec_lvl,
    output logic              take
);

    logic boundary_ok;

    assign boundary_ok = insn_done & ~reti_done;
    assign take        = vec_req & vec_ack;
    assign vec_addr    = irq_vec_addr(VEC_BASE, VEC_SHIFT, vec_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_req <= 1'b0;
            vec_idx <= '0;
            vec_lvl <= LVL_LO;
        end else if (take) begin
            vec_req <= 1'b0;
        end else if (!vec_req && pick.valid && boundary_ok) begin
            vec_req <= 1'b1;
            vec_idx <= pick.idx;
            vec_lvl <= pick.lvl;
        end
    end

    // R6, R8: a request starts only at a plain instruction boundary
    p_gate_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> ($past(insn_done) && !$past(reti_done)));

    // R7: the request and its address hold until acknowledged
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !vec_ack) |=> (vec_req && $stable(vec_addr)));

    // R7: acknowledge retires the request
    p_ack_drop_r7: assert property (@(posedge clk) disable iff (rst)
        take |=> !vec_req);

    // R4: no new request was decided while a high handler ran
    p_no_hi_preempt_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> !$past(insv.hi, 2));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int                NSRC      = 8,
    parameter logic [NSRC-1:0]   AUTOCLR   = 8'b0000_0011,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 16'h0003,
    parameter int unsigned       VEC_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   hw_evt,
    input  logic [NSRC-1:0]   sw_set,
    input  logic [NSRC-1:0]   sw_clr,
    input  logic              glob_en,
    input  logic [NSRC-1:0]   src_en,
    input  logic [NSRC-1:0]   src_prio,
    input  logic              insn_done,
    input  logic              reti_done,
    input  logic              vec_ack,
    output logic              vec_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [NSRC-1:0]   pend,
    output logic              insv_lo,
    output logic              insv_hi
);

    irq_pick_t        pick;
    irq_insv_t        insv;
    irq_lvl_e         vec_lvl;
    logic [IDX_W-1:0] vec_idx;
    logic             take;
    logic [NSRC-1:0]  ack_clr;

    for (genvar i = 0; i < NSRC; i++) begin : g_dec
        assign ack_clr[i] = take && (vec_idx == IDX_W'(i));
    end

    prio_irq_pend_bank #(
        .NSRC    (NSRC),
        .AUTOCLR (AUTOCLR)
    ) u_pend (
        .clk     (clk),
        .rst     (rst),
        .hw_evt  (hw_evt),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .ack_clr (ack_clr),
        .pend    (pend)
    );

    prio_irq_arbiter #(
        .NSRC (NSRC)
    ) u_arb (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .src_en   (src_en),
        .src_prio (src_prio),
        .glob_en  (glob_en),
        .insv     (insv),
        .hold     (vec_req),
        .pick     (pick)
    );

    prio_irq_vec_issue #(
        .VEC_BASE  (VEC_BASE),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_issue (
        .clk       (clk),
        .rst       (rst),
        .pick      (pick),
        .insn_done (insn_done),
        .reti_done (reti_done),
        .vec_ack   (vec_ack),
        .insv      (insv),
        .vec_req   (vec_req),
        .vec_addr  (vec_addr),
        .vec_idx   (vec_idx),
        .vec_lvl   (vec_lvl),
        .take      (take)
    );

    prio_irq_nest u_nest (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .take_lvl (vec_lvl),
        .ret      (reti_done),
        .insv     (insv)
    );

    assign insv_lo = insv.lo;
    assign insv_hi = insv.hi;

    // R11: everything idle right after reset
    p_reset_idle_r11: assert property (@(posedge clk)
        $past(rst) |-> (!vec_req && !insv_lo && !insv_hi && pend == '0));

endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

    localparam int NSRC = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] hw_evt = '0;
    logic [NSRC-1:0] sw_set = '0;
    logic [NSRC-1:0] sw_clr = '0;
    logic            glob_en = 1'b0;
    logic [NSRC-1:0] src_en = '0;
    logic [NSRC-1:0] src_prio = '0;
    logic            insn_done = 1'b1;
    logic            reti_done = 1'b0;
    logic            vec_ack = 1'b0;
    logic            vec_req;
    logic [15:0]     vec_addr;
    logic [NSRC-1:0] pend;
    logic            insv_lo;
    logic            insv_hi;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .hw_evt    (hw_evt),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr),
        .glob_en   (glob_en),
        .src_en    (src_en),
        .src_prio  (src_prio),
        .insn_done (insn_done),
        .reti_done (reti_done),
        .vec_ack   (vec_ack),
        .vec_req   (vec_req),
        .vec_addr  (vec_addr),
        .pend      (pend),
        .insv_lo   (insv_lo),
        .insv_hi   (insv_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_vec(input int idx);
        exp_q.push_back(16'h0003 + 16'(idx * 8));
    endtask

    task automatic pulse_evt(input logic [NSRC-1:0] m);
        hw_evt = m;
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic pulse_set(input logic [NSRC-1:0] m);
        sw_set = m;
        @(negedge clk);
        sw_set = '0;
    endtask

    task automatic pulse_clr(input logic [NSRC-1:0] m);
        sw_clr = m;
        @(negedge clk);
        sw_clr = '0;
    endtask

    task automatic do_ret();
        logic keep;
        keep      = insn_done;
        insn_done = 1'b1;
        reti_done = 1'b1;
        @(negedge clk);
        reti_done = 1'b0;
        insn_done = keep;
    endtask

    // Monitor: acknowledges each request and compares against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (vec_ack) begin
                vec_ack = 1'b0;
            end else if (vec_req && !rst) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R5 unexpected vector actual=%0h expected=none", vec_addr);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    if (vec_addr !== e) begin
                        fails++;
                        $display("FAIL R7 vector actual=%0h expected=%0h", vec_addr, e);
                    end
                end
                vec_ack = 1'b1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R11 reset state
        chk("R11 vec_req", 32'(vec_req), 0);
        chk("R11 pend", 32'(pend), 0);
        chk("R11 insv", 32'({insv_hi, insv_lo}), 0);

        src_en   = 8'hFF;
        src_prio = 8'b1110_0000;

        // R1/R2: global mask
        pulse_evt(8'h08);
        step(4);
        chk("R1 flag set while masked", 32'(pend[3]), 1);
        chk("R2 global mask", 32'(vec_req), 0);
        glob_en  = 1'b1;
        src_en   = 8'hF7;
        step(4);
        chk("R2 source disabled", 32'(vec_req), 0);
        pulse_clr(8'h08);
        chk("R3 software clear", 32'(pend[3]), 0);
        src_en = 8'hFF;

        // R3/R6/R9: software set of auto-clear source 0, exact latency
        expect_vec(0);
        pulse_set(8'h01);
        step(1);
        chk("R6 not before edge n+2", 32'(vec_req), 0);
        step(1);
        chk("R6 request at edge n+2", 32'(vec_req), 1);
        chk("R7 address source 0", 32'(vec_addr), 32'h0003);
        step(2);
        chk("R9 auto-clear source 0", 32'(pend[0]), 0);
        chk("R10 low in service", 32'({insv_hi, insv_lo}), 32'b01);
        do_ret();
        chk("R10 return clears low", 32'({insv_hi, insv_lo}), 0);

        // R6: no request without instruction boundary
        insn_done = 1'b0;
        expect_vec(2);
        pulse_evt(8'h04);
        step(4);
        chk("R6 waits for boundary", 32'(vec_req), 0);
        insn_done = 1'b1;
        step(3);
        chk("R9 source 2 keeps flag", 32'(pend[2]), 1);
        pulse_clr(8'h04);
        do_ret();

        // R5 same-level tie, R4 low cannot preempt low
        expect_vec(1);
        pulse_evt(8'h0A);
        step(4);
        chk("R9 auto-clear source 1", 32'(pend[1]), 0);
        chk("R9 source 3 still pending", 32'(pend[3]), 1);
        chk("R4 low blocked by low", 32'(vec_req), 0);
        expect_vec(3);
        do_ret();
        step(4);
        chk("R10 source 3 in service", 32'(insv_lo), 1);
        pulse_clr(8'h08);
        do_ret();

        // R5 simultaneous levels: high 5 first, then low 2
        expect_vec(5);
        expect_vec(2);
        pulse_evt(8'h24);
        step(4);
        chk("R10 high in service", 32'({insv_hi, insv_lo}), 32'b10);
        pulse_clr(8'h20);
        do_ret();
        step(4);
        chk("R5 low served after high", 32'({insv_hi, insv_lo}), 32'b01);
        pulse_clr(8'h04);
        do_ret();

        // R4 preemption of low handler, blocked attempt during high
        expect_vec(4);
        pulse_evt(8'h10);
        step(4);
        pulse_clr(8'h10);
        expect_vec(6);
        pulse_evt(8'h40);
        step(4);
        chk("R4 high preempts low", 32'({insv_hi, insv_lo}), 32'b11);
        pulse_evt(8'h80);
        step(5);
        chk("R4 high not preempted", 32'(vec_req), 0);
        chk("R4 source 7 pending", 32'(pend[7]), 1);
        pulse_clr(8'h80);

        // R8 one-instruction rule: source 6 still pending
        insn_done = 1'b0;
        do_ret();
        step(1);
        do_ret();
        chk("R8 no vector at return boundary", 32'(vec_req), 0);
        chk("R10 both levels ended", 32'({insv_hi, insv_lo}), 0);
        expect_vec(6);
        insn_done = 1'b1;
        step(4);
        chk("R8 vector after one instruction", 32'(insv_hi), 1);
        pulse_clr(8'h40);
        do_ret();

        step(10);
        chk("R7 scoreboard drained", 32'(exp_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule